// File: doc/BRIEF.md
# Self-Starting Shift-Register Counter

This block is a four-stage shift register that counts by moving a pattern along its stages. A parameter selects one of two feedback styles. In rotate mode, the last stage is copied back into the first, so a single 1 circulates through four states. In twisted mode, the last stage is inverted before it is fed back, which gives eight states in which exactly one bit changes per step. Such counters drive glitch-free sequencing and phase strobes, because each state differs from its neighbour in very few bits.

The register moves only on a clock edge where the shift enable is high. An asynchronous active-low reset puts it into a known legal state. At power-up the flops can hold any of the sixteen patterns, so a small correction term in the feedback path steers every illegal pattern into the legal cycle after a few shifts, with no reset needed. A synchronous test load port can force any pattern, and a combinational flag reports whether the present pattern is one of the legal states of the selected mode.

Top module: `shiftring_ctr`

## Requirements
- R1: While rst_n is low, state is 4'b0001 in rotate mode and 4'b0000 in twisted mode, whatever shift_en does. Stage k of the register is bit k of state, and stage 0 is the first stage.
- R2: On an edge where shift_en and load_en are both low, state keeps its value.
- R3: In rotate mode a shift from a legal state moves every stage k into stage k+1 and moves stage 3 into stage 0, giving 0001, 0010, 0100, 1000, 0001 as hex-free binary values. The result stays legal.
- R4: In twisted mode a shift from a legal state moves stage k into stage k+1 and puts the inverse of stage 3 into stage 0. Exactly one bit changes per shift and the result stays legal.
- R5: On an edge with load_en high, state takes load_val on the next edge, and load_en takes priority over shift_en.
- R6: In rotate mode, valid is high exactly when state has exactly one bit set.
- R7: In twisted mode, valid is high exactly when state is one of 0, 1, 3, 7, 15, 14, 12 or 8 (decimal).
- R8: In rotate mode, from any of the 16 patterns, valid goes high after at most 3 shifts and stays high on further shifts.
- R9: In twisted mode, from any of the 16 patterns, valid goes high after at most 5 shifts and stays high on further shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to the legal start state |
| shift_en | input | 1 | Advance the register by one stage on this edge |
| load_en | input | 1 | Load load_val into the register on this edge (test use) |
| load_val | input | 4 | Pattern to load, bit k goes to stage k |
| state | output | 4 | Present stage contents, bit k is stage k |
| valid | output | 1 | High when state is a legal state of the selected mode |

## Verification
The properties assume that load_en is a test path used between shifting runs: the bound on shifts spent in illegal states restarts on every load, so it says nothing about a register reloaded with illegal patterns over and over. They also assume shift_en and load_en change synchronously to clk. The stimulus drives both enables on the falling edge, uses a single-cycle load pulse per pattern, and then shifts without loading while it measures how many shifts the register needs to reach the legal cycle, for all sixteen patterns and both modes.

// File: rtl/shiftring_pkg.sv
package shiftring_pkg;

    localparam int unsigned STAGES = 4;
    localparam int unsigned EDGES  = STAGES - 1;

    typedef logic [STAGES-1:0] stage_vec_t;

    typedef enum logic {
        MODE_RING  = 1'b0,
        MODE_TWIST = 1'b1
    } fb_mode_e;

    typedef struct packed {
        stage_vec_t stages;
    } ctr_regs_t;

endpackage

// File: rtl/shiftring_step.sv
module shiftring_step
    import shiftring_pkg::*;
#(
    parameter fb_mode_e MODE = MODE_RING
) (
    input  stage_vec_t cur,
    output stage_vec_t nxt
);

    generate
        if (MODE == MODE_RING) begin : g_ring
            // A 1 enters only when the stages that will follow stage 0 are empty,
            // so extra ones drain out and an all-zero register gets a token.
            always_comb begin
                nxt    = {cur[STAGES-2:0], 1'b0};
                nxt[0] = ~|cur[STAGES-2:0];
            end
        end else begin : g_twist
            // Stage 2 only takes a 1 if stage 1 is backed by a neighbour,
            // which breaks the isolated-one patterns of the illegal loop.
            always_comb begin
                nxt    = {cur[STAGES-2:0], ~cur[STAGES-1]};
                nxt[2] = cur[1] & (cur[0] | cur[2]);
            end
        end
    endgenerate

endmodule

// File: rtl/shiftring_legal.sv
module shiftring_legal
    import shiftring_pkg::*;
#(
    parameter fb_mode_e MODE = MODE_RING
) (
    input  stage_vec_t cur,
    output logic       legal
);

    generate
        if (MODE == MODE_RING) begin : g_ring
            always_comb begin
                legal = (cur != '0) && ((cur & (cur - stage_vec_t'(1))) == '0);
            end
        end else begin : g_twist
            logic [EDGES-1:0] flips;
            for (genvar i = 0; i < EDGES; i++) begin : g_flip
                assign flips[i] = cur[i] ^ cur[i+1];
            end
            // Legal twisted states hold one run of ones and one run of zeros.
            always_comb begin
                legal = (flips & (flips - (EDGES)'(1))) == '0;
            end
        end
    endgenerate

endmodule

// File: rtl/shiftring_ctr.sv
module shiftring_ctr
    import shiftring_pkg::*;
#(
    parameter fb_mode_e MODE = MODE_RING
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic [STAGES-1:0] load_val,
    output logic [STAGES-1:0] state,
    output logic              valid
);

    localparam stage_vec_t INIT_PAT = (MODE == MODE_RING) ? stage_vec_t'(1) : '0;

    ctr_regs_t  regs_d;
    ctr_regs_t  regs_q;
    stage_vec_t stepped;

    shiftring_step #(.MODE(MODE)) u_step (
        .cur (regs_q.stages),
        .nxt (stepped)
    );

    shiftring_legal #(.MODE(MODE)) u_legal (
        .cur   (regs_q.stages),
        .legal (valid)
    );

    always_comb begin
        regs_d = regs_q;
        if (load_en) begin
            regs_d.stages = load_val;
        end else if (shift_en) begin
            regs_d.stages = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{stages: INIT_PAT};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state = regs_q.stages;

endmodule

// File: rtl/shiftring_ctr_chk.sv
module shiftring_ctr_chk
    import shiftring_pkg::*;
#(
    parameter fb_mode_e MODE = MODE_RING
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en,
    input logic              load_en,
    input logic [STAGES-1:0] load_val,
    input logic [STAGES-1:0] state,
    input logic              valid
);

    localparam int unsigned SETTLE = (MODE == MODE_RING) ? 3 : 5;

    logic [3:0] miss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else if (load_en || valid) begin
            miss_q <= '0;
        end else if (shift_en && miss_q != 4'hF) begin
            miss_q <= miss_q + 4'd1;
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(state));

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state == $past(load_val)));

    // R3 R4
    legal_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && shift_en && !load_en) |=> valid);

    // R8 R9
    settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q <= 4'(SETTLE));

    generate
        if (MODE == MODE_RING) begin : g_ring
            // R3
            rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid && shift_en && !load_en) |=>
                (state == {$past(state[STAGES-2:0]), $past(state[STAGES-1])}));
        end else begin : g_twist
            // R4
            twist_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (valid && shift_en && !load_en) |=>
                ($countones(state ^ $past(state)) == 1));
        end
    endgenerate

endmodule

bind shiftring_ctr shiftring_ctr_chk #(.MODE(MODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .load_val (load_val),
    .state    (state),
    .valid    (valid)
);

// File: tb/sim_shiftring_ctr.sv
module sim_shiftring_ctr;
    import shiftring_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       shift_en;
    logic       load_en;
    logic [3:0] load_val;
    logic [3:0] r_state, t_state;
    logic       r_valid, t_valid;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [3:0] r_exp;
        logic       r_ok;
        logic [3:0] t_exp;
        logic       t_ok;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [3:0] mr, mt;

    always #10 clk = ~clk;

    shiftring_ctr #(.MODE(MODE_RING)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_en(load_en),
        .load_val(load_val), .state(r_state), .valid(r_valid));

    shiftring_ctr #(.MODE(MODE_TWIST)) u1 (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_en(load_en),
        .load_val(load_val), .state(t_state), .valid(t_valid));

    function automatic logic ring_ok(input logic [3:0] v);
        return $countones(v) == 1;
    endfunction

    function automatic logic twist_ok(input logic [3:0] v);
        return v inside {4'd0, 4'd1, 4'd3, 4'd7, 4'd15, 4'd14, 4'd12, 4'd8};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: apply one edge worth of inputs and push what must follow.
    task automatic step(input logic sh, input logic ld, input logic [3:0] v,
                        input string tag);
        item_t it;
        @(negedge clk);
        shift_en = sh;
        load_en  = ld;
        load_val = v;
        if (ld) begin
            mr = v;
            mt = v;
        end else if (sh) begin
            mr = {mr[2:0], mr[3]};
            mt = {mt[2:0], ~mt[3]};
        end
        it.r_exp = mr;
        it.r_ok  = ring_ok(mr);
        it.t_exp = mt;
        it.t_ok  = twist_ok(mt);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (rst_n === 1'b1 && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(r_state === it.r_exp, it.tag, "rotate state", r_state, it.r_exp);
                check(r_valid === it.r_ok, it.tag, "rotate valid", {3'b0, r_valid}, {3'b0, it.r_ok});
                check(t_state === it.t_exp, it.tag, "twisted state", t_state, it.t_exp);
                check(t_valid === it.t_ok, it.tag, "twisted valid", {3'b0, t_valid}, {3'b0, it.t_ok});
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        shift_en = 1'b1;
        load_en  = 1'b0;
        load_val = 4'd0;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state while shift_en is high
        check(r_state === 4'b0001, "R1", "rotate reset", r_state, 4'b0001);
        check(t_state === 4'b0000, "R1", "twisted reset", t_state, 4'b0000);
        check(r_valid === 1'b1, "R6", "rotate reset valid", {3'b0, r_valid}, 4'd1);
        check(t_valid === 1'b1, "R7", "twisted reset valid", {3'b0, t_valid}, 4'd1);
        @(negedge clk);
        shift_en = 1'b0;
        rst_n    = 1'b1;
        mr = 4'b0001;
        mt = 4'b0000;

        repeat (10) step(1'b1, 1'b0, 4'd0, "R3 R4 advance");
        repeat (3)  step(1'b0, 1'b0, 4'd5, "R2 hold");
        step(1'b1, 1'b1, 4'b1000, "R5 load over shift");
        repeat (5)  step(1'b1, 1'b0, 4'd0, "R3 R4 after load");
        step(1'b0, 1'b0, 4'd0, "R2 hold");
        step(1'b0, 1'b1, 4'b0100, "R5 load");
        step(1'b0, 1'b0, 4'd0, "R2 hold");
        while (sb_q.size() > 0) @(negedge clk);

        // Every pattern: classify, then measure shifts to the legal cycle.
        for (int v = 0; v < 16; v++) begin
            int r_first = -1;
            int t_first = -1;
            @(negedge clk);
            load_en  = 1'b1;
            shift_en = 1'b0;
            load_val = 4'(v);
            @(negedge clk);
            load_en  = 1'b0;
            check(r_valid === ring_ok(4'(v)), "R6", "rotate flag", {3'b0, r_valid}, {3'b0, ring_ok(4'(v))});
            check(t_valid === twist_ok(4'(v)), "R7", "twisted flag", {3'b0, t_valid}, {3'b0, twist_ok(4'(v))});
            if (r_valid) r_first = 0;
            if (t_valid) t_first = 0;
            shift_en = 1'b1;
            for (int n = 1; n <= 8; n++) begin
                @(negedge clk);
                if (r_first < 0 && r_valid) r_first = n;
                if (t_first < 0 && t_valid) t_first = n;
            end
            shift_en = 1'b0;
            check(r_first >= 0 && r_first <= 3, "R8", "rotate settle shifts", 4'(r_first), 4'd3);
            check(t_first >= 0 && t_first <= 5, "R9", "twisted settle shifts", 4'(t_first), 4'd5);
            check(r_valid === 1'b1, "R8", "rotate stays legal", {3'b0, r_valid}, 4'd1);
            check(t_valid === 1'b1, "R9", "twisted stays legal", {3'b0, t_valid}, 4'd1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule